// File: doc/BRIEF.md
# BLDC Commutation PWM Steering Controller

This block steers a PWM signal onto the switches of a six-switch sensorless brushless DC motor bridge. Every motor step is split by three event pulses into three intervals. A commutation pulse (C) starts the first interval. A demagnetization-end pulse (D) starts the second. A zero-crossing pulse (Z) starts the third, which lasts until the next C. For each interval, software picks whether the PWM chops the high-side switch group or the low-side group. The active switch of the other group is held on steadily. A per-step phase pattern chooses which high-side and which low-side switch take part.

A byte-wide register bus carries the settings. Some of the control fields are double-buffered: a write lands in a shadow copy, and the copy drives the hardware only from the next C event onward. The shadowed fields are the zero-crossing edge select, the two demagnetization enables and the first-interval steering bit. When direct stepping is enabled, every write to the phase pattern register counts as a C event.

The block also applies an over-current policy when the current-limit comparator is active. It either cuts the PWM until the next PWM period begins, or it clears the master output enable so that every switch turns off. It raises an interrupt in the cases that call for one.

Top module: `bldc_step_steer`

## Requirements
- R1: After reset, all three registers read 00h, `out_en` is 0, all gates are 0, `zc_rising`, `hdm_en` and `sdm_en` are 0, and the interval is the first (C to D).
- R2: The register map is as follows; reading address 3 returns 00h.
  - Address 0 is the control register. Bit 7 always reads 0. Bit 6 is the zero-crossing edge select (1 = rising). Bit 5 enables hardware demagnetization. Bit 4 enables simulated demagnetization. Bit 3 is the over-current shutdown select. Bits 2..0 are the steering bits.
  - Address 1 is the phase pattern. Bits NCH-1..0 are the high-side enables and bits 2*NCH-1..NCH are the low-side enables.
  - Address 2 is the configuration register. Bit 0 is direct stepping, bit 1 is the current-limit mode and bit 2 is the master output enable.
  - Reads of address 0 return the last written bits 6..0.
- R3: Control bits 6, 5, 4 and 2 are preloaded. `zc_rising`, `hdm_en`, `sdm_en` and the first-interval steering change only in the cycle after a C event. A C event in the same cycle as a control write loads the newly written value.
- R4: With direct stepping set, a write to address 1 acts as a C event: it restarts the first interval and loads the preloaded fields. With direct stepping clear, such a write is not a C event.
- R5: The intervals advance as follows, and all other D and Z pulses are ignored.
  - C always enters the C-to-D interval, and C has priority over D and Z.
  - D moves from C-to-D to D-to-Z.
  - Z moves from D-to-Z to Z-to-C.
- R6: The steering bits choose where the PWM goes in each interval. The active (preloaded) bit 2 applies between C and D, bit 1 between D and Z, and bit 0 between Z and C. A 0 chops the PWM on the enabled high-side gates and holds the enabled low-side gates on; a 1 does the reverse. Bits 1 and 0 take effect in the cycle after they are written.
- R7: While the comparator `ilim_cmp` is low, the gates follow R6 and `irq` stays low in the next cycle.
- R8: When `ilim_cmp` is high and the current-limit mode is 0, the PWM-carrying gates are forced low in that same cycle, with no interrupt. The cut persists until the PWM input rises while the comparator is low.
- R9: With the current-limit mode at 1 and control bit 3 at 0, an active comparator cuts the PWM as in R8 and also raises an interrupt.
- R10: With the current-limit mode at 1 and control bit 3 at 1, an active comparator clears the master output enable in the next cycle. All gates then stay low until software writes bit 2 of the configuration register to 1. A trip wins over a write made in the same cycle.
- R11: `irq` is a one-cycle pulse. It is issued in the cycle after the condition "comparator high and current-limit mode 1" becomes true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Write address |
| bus_wdata | input | 8 | Write data |
| bus_raddr | input | 2 | Read address |
| bus_rdata | output | 8 | Read data, combinational |
| evt_c | input | 1 | Commutation event pulse |
| evt_d | input | 1 | Demagnetization-end event pulse |
| evt_z | input | 1 | Zero-crossing event pulse |
| ilim_cmp | input | 1 | Current-limit comparator, active high |
| pwm_in | input | 1 | PWM signal to be steered |
| hi_gate | output | NCH | High-side switch gates |
| lo_gate | output | NCH | Low-side switch gates |
| zc_rising | output | 1 | Active zero-crossing edge select |
| hdm_en | output | 1 | Active hardware demagnetization enable |
| sdm_en | output | 1 | Active simulated demagnetization enable |
| out_en | output | 1 | Master output enable |
| irq | output | 1 | Over-current interrupt pulse |

## Verification
The assertions assume that every input is synchronous to `clk`, holds a known value from the first edge after reset, and is stable around the rising edge. They also assume that only one register write happens per cycle. The stimulus meets these conditions by changing every input, the bus included, only at the falling edge from a single process. The event pulses, the comparator and the PWM are random single bits, so out-of-order D and Z pulses, C pulses that coincide with D and Z, and comparator trips in every mode are all reached. The comparator is held low most of the time so that normal steering stays well covered.

// File: rtl/bldc_step_steer.sv
module bldc_step_steer #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [1:0]     bus_addr,
  input  logic [7:0]     bus_wdata,
  input  logic [1:0]     bus_raddr,
  output logic [7:0]     bus_rdata,
  input  logic           evt_c,
  input  logic           evt_d,
  input  logic           evt_z,
  input  logic           ilim_cmp,
  input  logic           pwm_in,
  output logic [NCH-1:0] hi_gate,
  output logic [NCH-1:0] lo_gate,
  output logic           zc_rising,
  output logic           hdm_en,
  output logic           sdm_en,
  output logic           out_en,
  output logic           irq
);
  localparam int PW = 2 * NCH;

  logic [6:0]    ctl_q, ctl_nx;
  logic [3:0]    act_q;
  logic [PW-1:0] ph_q;
  logic          dir_q, lim_q, moe_q;
  logic [2:0]    st_q;
  logic          pwm_d, cut_q, cond_d, irq_q;

  logic wr_ctl, wr_ph, wr_cfg, c_evt;
  logic oc_trip, cut_set, cond, pwm_rise, pwm_g, lo_side;
  logic unused_bits;

  assign wr_ctl = bus_wr && (bus_addr == 2'd0);
  assign wr_ph  = bus_wr && (bus_addr == 2'd1);
  assign wr_cfg = bus_wr && (bus_addr == 2'd2);
  assign ctl_nx = wr_ctl ? bus_wdata[6:0] : ctl_q;
  assign c_evt  = evt_c | (wr_ph & dir_q);
  assign unused_bits = ^bus_wdata[7:PW];

  assign cond     = ilim_cmp & lim_q;
  assign oc_trip  = cond & ctl_q[3];
  assign cut_set  = ilim_cmp & ~oc_trip;
  assign pwm_rise = pwm_in & ~pwm_d;
  assign pwm_g    = pwm_in & ~cut_set & ~(cut_q & ~pwm_rise);
  assign lo_side  = |(st_q & {ctl_q[0], ctl_q[1], act_q[0]});

  assign hi_gate = {NCH{moe_q}} & ph_q[NCH-1:0] & (lo_side ? {NCH{1'b1}} : {NCH{pwm_g}});
  assign lo_gate = {NCH{moe_q}} & ph_q[PW-1:NCH] & (lo_side ? {NCH{pwm_g}} : {NCH{1'b1}});

  assign zc_rising = act_q[3];
  assign hdm_en    = act_q[2];
  assign sdm_en    = act_q[1];
  assign out_en    = moe_q;
  assign irq       = irq_q;

  always_comb begin
    case (bus_raddr)
      2'd0:    bus_rdata = {1'b0, ctl_q};
      2'd1:    bus_rdata = {{(8-PW){1'b0}}, ph_q};
      2'd2:    bus_rdata = {5'd0, moe_q, lim_q, dir_q};
      default: bus_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0; act_q <= '0; ph_q <= '0;
      dir_q <= 1'b0; lim_q <= 1'b0; moe_q <= 1'b0;
      st_q  <= 3'b001;
      pwm_d <= 1'b0; cut_q <= 1'b0; cond_d <= 1'b0; irq_q <= 1'b0;
    end else begin
      ctl_q <= ctl_nx;
      if (c_evt) act_q <= {ctl_nx[6:4], ctl_nx[2]};
      if (wr_ph) ph_q <= bus_wdata[PW-1:0];
      if (wr_cfg) begin
        dir_q <= bus_wdata[0];
        lim_q <= bus_wdata[1];
      end
      if (oc_trip)     moe_q <= 1'b0;
      else if (wr_cfg) moe_q <= bus_wdata[2];

      if (c_evt)                 st_q <= 3'b001;
      else if (evt_d && st_q[0]) st_q <= 3'b010;
      else if (evt_z && st_q[1]) st_q <= 3'b100;

      pwm_d <= pwm_in;
      if (cut_set)       cut_q <= 1'b1;
      else if (pwm_rise) cut_q <= 1'b0;
      cond_d <= cond;
      irq_q  <= cond & ~cond_d;
    end
  end
endmodule

module bldc_step_steer_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     bus_raddr,
  input logic [7:0]     bus_rdata,
  input logic           ilim_cmp,
  input logic           lim_q,
  input logic           oc_trip,
  input logic           c_evt,
  input logic           lo_side,
  input logic [2:0]     st_q,
  input logic [NCH-1:0] hi_gate,
  input logic [NCH-1:0] lo_gate,
  input logic           zc_rising,
  input logic           hdm_en,
  input logic           sdm_en,
  input logic           out_en,
  input logic           irq
);
  p_rd_bit7_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_raddr == 2'd0) |-> (bus_rdata[7] == 1'b0));

  p_preload_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !c_evt |=> $stable({zc_rising, hdm_en, sdm_en}));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    c_evt |=> (st_q == 3'b001));

  p_one_interval_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_q) == 1);

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ilim_cmp |=> !irq);

  p_cut_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_cmp && !oc_trip && !lo_side) |-> (hi_gate == '0));

  p_cut_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ilim_cmp && !oc_trip && lo_side) |-> (lo_gate == '0));

  p_shutdown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip |=> (!out_en && hi_gate == '0 && lo_gate == '0));

  p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ilim_cmp && lim_q));

  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

bind bldc_step_steer bldc_step_steer_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
  .ilim_cmp(ilim_cmp), .lim_q(lim_q), .oc_trip(oc_trip), .c_evt(c_evt),
  .lo_side(lo_side), .st_q(st_q), .hi_gate(hi_gate), .lo_gate(lo_gate),
  .zc_rising(zc_rising), .hdm_en(hdm_en), .sdm_en(sdm_en),
  .out_en(out_en), .irq(irq));

// File: tb/test_bldc_step_steer.sv
module test_bldc_step_steer;
  localparam int NCH = 3;
  localparam int PW = 2 * NCH;
  localparam time T_CLK = 10ns;
  localparam int N_RAND = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = '0, bus_raddr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic evt_c = 1'b0, evt_d = 1'b0, evt_z = 1'b0, ilim_cmp = 1'b0, pwm_in = 1'b0;
  logic [NCH-1:0] hi_gate, lo_gate;
  logic zc_rising, hdm_en, sdm_en, out_en, irq;

  int n_chk = 0, n_err = 0;

  always #(T_CLK/2) clk = ~clk;

  bldc_step_steer #(.NCH(NCH)) i_bldc_step_steer (.*);

  logic [6:0] m_ctl, nctl;
  logic [3:0] m_act;
  logic [PW-1:0] m_ph;
  logic m_dir, m_lim, m_moe, m_pwm_d, m_cut, m_cond_d, m_irq;
  int m_st;
  logic m_cdir, m_adv, tc, tcond, ttrip, tw0, tw1, tw2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = '0; m_act = '0; m_ph = '0; m_dir = 0; m_lim = 0; m_moe = 0;
      m_pwm_d = 0; m_cut = 0; m_cond_d = 0; m_irq = 0; m_st = 0;
      m_cdir = 0; m_adv = 0;
    end else begin
      tw0 = bus_wr && bus_addr == 2'd0;
      tw1 = bus_wr && bus_addr == 2'd1;
      tw2 = bus_wr && bus_addr == 2'd2;
      tc = evt_c | (tw1 & m_dir);
      m_cdir = tw1 & m_dir;
      tcond = ilim_cmp & m_lim;
      ttrip = tcond & m_ctl[3];
      m_irq = tcond & ~m_cond_d;
      m_cond_d = tcond;
      if (ilim_cmp && !ttrip) m_cut = 1;
      else if (pwm_in && !m_pwm_d) m_cut = 0;
      m_pwm_d = pwm_in;
      nctl = tw0 ? bus_wdata[6:0] : m_ctl;
      if (tc) m_act = {nctl[6:4], nctl[2]};
      m_adv = 0;
      if (tc) m_st = 0;
      else if (evt_d && m_st == 0) begin m_st = 1; m_adv = 1; end
      else if (evt_z && m_st == 1) begin m_st = 2; m_adv = 1; end
      m_ctl = nctl;
      if (tw1) m_ph = bus_wdata[PW-1:0];
      if (ttrip) m_moe = 0;
      else if (tw2) m_moe = bus_wdata[2];
      if (tw2) begin m_dir = bus_wdata[0]; m_lim = bus_wdata[1]; end
    end
  end

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {1'b0, m_ctl};
      2'd1: return {{(8-PW){1'b0}}, m_ph};
      2'd2: return {5'd0, m_moe, m_lim, m_dir};
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [PW-1:0] exp_gates();
    logic pg, lo, trip;
    logic [NCH-1:0] h, l;
    trip = ilim_cmp & m_lim & m_ctl[3];
    pg = pwm_in & ~(ilim_cmp & ~trip) & ~(m_cut & ~(pwm_in & ~m_pwm_d));
    lo = (m_st == 0) ? m_act[0] : (m_st == 1) ? m_ctl[1] : m_ctl[0];
    h = m_ph[NCH-1:0] & (lo ? {NCH{1'b1}} : {NCH{pg}});
    l = m_ph[PW-1:NCH] & (lo ? {NCH{pg}} : {NCH{1'b1}});
    return m_moe ? {l, h} : '0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string gt, it;
    chk("R2", {24'd0, bus_rdata}, {24'd0, exp_rd(bus_raddr)});
    chk("R3", {29'd0, zc_rising, hdm_en, sdm_en}, {29'd0, m_act[3:1]});
    if (m_cdir) gt = "R4";
    else if (!m_moe) gt = "R10";
    else if (ilim_cmp && m_lim && !m_ctl[3]) gt = "R9";
    else if (ilim_cmp || m_cut) gt = "R8";
    else if (m_adv) gt = "R5";
    else gt = "R6";
    chk(gt, {{(32-PW){1'b0}}, lo_gate, hi_gate}, {{(32-PW){1'b0}}, exp_gates()});
    chk("R10", {31'd0, out_en}, {31'd0, m_moe});
    if (!m_cond_d) it = "R7";
    else if (m_irq && !m_ctl[3]) it = "R9";
    else it = "R11";
    chk(it, {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
    bus_wr = 0; evt_c = 0; evt_d = 0; evt_z = 0;
  endtask

  initial begin
    fork
      begin
        #(T_CLK * 150000);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    join_none
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 4; a++) begin
      bus_raddr = 2'(a);
      #1;
      chk("R1", {24'd0, bus_rdata}, 32'd0);
    end
    chk("R1", {24'd0, lo_gate, hi_gate, out_en, zc_rising, hdm_en, sdm_en}, 32'd0);
    bus_raddr = 0;
    step();
    // R3 preload
    bus_wr = 1; bus_addr = 0; bus_wdata = 8'hF0;
    step();
    chk("R3", {31'd0, zc_rising}, 32'd0);
    chk("R2", {24'd0, bus_rdata}, 32'h70);
    evt_c = 1;
    step();
    chk("R3", {29'd0, zc_rising, hdm_en, sdm_en}, 32'd7);
    // R4 direct stepping
    bus_wr = 1; bus_addr = 2; bus_wdata = 8'h05;
    step();
    bus_wr = 1; bus_addr = 0; bus_wdata = 8'h00;
    step();
    bus_wr = 1; bus_addr = 1; bus_wdata = 8'h0A;
    step();
    chk("R4", {29'd0, zc_rising, hdm_en, sdm_en}, 32'd0);
    // R5 ignored Z in first interval, steering bit1=1
    bus_wr = 1; bus_addr = 0; bus_wdata = 8'h02; pwm_in = 0;
    step();
    evt_z = 1;
    step();
    chk("R5", {26'd0, lo_gate, hi_gate}, {26'd0, 3'b001, 3'b000});
    // R10 trip and re-enable
    bus_wr = 1; bus_addr = 2; bus_wdata = 8'h06;
    step();
    bus_wr = 1; bus_addr = 0; bus_wdata = 8'h08;
    step();
    ilim_cmp = 1;
    step();
    ilim_cmp = 0;
    step();
    chk("R10", {31'd0, out_en}, 32'd0);
    step();
    chk("R10", {31'd0, out_en}, 32'd0);
    bus_wr = 1; bus_addr = 2; bus_wdata = 8'h04;
    step();
    chk("R10", {31'd0, out_en}, 32'd1);

    for (int i = 0; i < N_RAND; i++) begin
      evt_c = ($urandom % 12) == 0;
      evt_d = ($urandom % 5) == 0;
      evt_z = ($urandom % 5) == 0;
      ilim_cmp = ($urandom % 10) == 0;
      if (($urandom % 3) == 0) pwm_in = ~pwm_in;
      bus_raddr = 2'($urandom);
      if (($urandom % 5) == 0) begin
        bus_wr = 1;
        bus_addr = 2'($urandom);
        bus_wdata = 8'($urandom);
        if (bus_addr == 2'd2) bus_wdata[2] = ($urandom % 4) != 0;
      end
      if (!out_en && ($urandom % 8) == 0) begin
        bus_wr = 1; bus_addr = 2; bus_wdata = {5'd0, 1'b1, 2'($urandom)};
      end
      step();
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule